// File: doc/BRIEF.md
# Two-Wire Slave Register Window

This block is a target on a two-wire serial bus. It exposes a 64-byte register window to a bus controller. The low eight addresses belong to a timekeeper that sits outside the block. The remaining 56 addresses are general-purpose byte storage held inside the block.

Both bus lines are oversampled by the system clock. The block finds bus conditions from the sampled lines, matches its fixed 7-bit device address and keeps a byte pointer that steps after every byte. That pointer wraps at the top of the window. The running time is presented on a 64-bit input. At every START the block copies it into a frozen snapshot, so a burst read of the time bytes returns values that belong together.

Bus writes that land on a timekeeper address are passed out as a one-cycle strobe. That strobe has no ready and cannot be stalled, so the timekeeper must take it in the cycle it is seen. A level-sensitive inhibit input cuts off the bus while the supply is unsafe.

Top module: `i2cs_regfile`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 7'b1101000. On any other address it leaves SDA released for the ninth clock and for every following byte, until the next START.
- R2: In a write transfer (R/W bit 0), the first byte after the address sets the pointer from its low six bits. Each further byte is stored at the pointer, after which the pointer steps by one. Every byte is acknowledged.
- R3: A read transfer (R/W bit 1) returns data starting at the current pointer, which steps by one after each byte. Without a pointer byte, the start value is where the previous transfer left the pointer.
- R4: The pointer wraps from 3Fh to 00h, for both reads and writes.
- R5: Reads of addresses 00h to 07h return the byte at bits [8*a+7:8*a] of the time input, as sampled at the most recent START. Later changes of the time input do not affect them.
- R6: Bytes move MSB first. The receiver acknowledges on the ninth clock by holding SDA low. The block changes what it drives on SDA only while SCL is low.
- R7: When the controller does not acknowledge a byte read, the block releases SDA and stays off the bus until the next START.
- R8: While inhibit is high, any transfer stops, SDA is released, the pointer becomes 00h, and bus activity is ignored. This includes START conditions and bytes that would otherwise be written.
- R9: A bus write to address a < 8 produces one cycle of clk_wr_valid, with clk_wr_addr = a and clk_wr_data equal to the byte. Writes to other addresses raise no strobe.
- R10: SDA is only ever pulled low, through sda_oe. After reset sda_oe is 0, no strobe is raised and the RAM bytes read as 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| inhibit | input | 1 | Blocks all bus access while high |
| time_i | input | 64 | Running time bytes, byte a at bits [8a+7:8a] |
| clk_wr_valid | output | 1 | One-cycle strobe for a bus write to a time byte |
| clk_wr_addr | output | 3 | Time byte index of the write |
| clk_wr_data | output | 8 | Byte written |

## Verification
The bench attacks several weak points of this block.

- **Pointer wrap.** A write burst runs from 3Fh into 00h. A pointer that saturates, or that wraps without reaching the time bytes, shows up as a missing strobe or a wrong second read byte.
- **Snapshot.** The time input changes in the middle of a burst read. A design that reads the live value instead of the snapshot returns mixed bytes.
- **Pointer persistence.** A read with no pointer byte must continue where the last transfer stopped. A design that clears the pointer at START fails this.
- **Inhibit.** Inhibit is raised in the middle of a data byte, and a START is sent while it is held. A design that keeps decoding would acknowledge that START, store the cut-off byte, or keep the old pointer.
- **NACK release.** After a NACK the bench checks that SDA is released. A design that keeps driving read bits would block the STOP.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_RD
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int NL = 2;
  logic [NL-1:0] raw;
  logic [NL-1:0] synced;
  logic [NL-1:0] last;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NL; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= '1;
    else        last <= synced;
  end

  assign scl_s    = synced[1];
  assign sda_s    = synced[0];
  assign scl_rise = synced[1] & ~last[1];
  assign scl_fall = ~synced[1] & last[1];
  assign start_ev = synced[1] & last[1] & ~synced[0] & last[0];
  assign stop_ev  = synced[1] & last[1] & synced[0] & ~last[0];
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs #(
  parameter int AW       = 6,
  parameter int CLK_REGS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [AW-1:0]               wr_addr,
  input  logic [7:0]                  wr_data,
  input  logic [AW-1:0]               rd_addr,
  output logic [7:0]                  rd_data,
  input  logic                        snap_take,
  input  logic [8*CLK_REGS-1:0]       time_i,
  output logic                        clk_wr_valid,
  output logic [$clog2(CLK_REGS)-1:0] clk_wr_addr,
  output logic [7:0]                  clk_wr_data
);
  localparam int DEPTH = 1 << AW;
  localparam int RAM_N = DEPTH - CLK_REGS;
  localparam int CAW   = $clog2(CLK_REGS);

  logic [7:0]            ram [RAM_N];
  logic [8*CLK_REGS-1:0] snap;
  logic                  in_clk_wr;
  logic                  in_clk_rd;
  logic [AW-1:0]         ram_wi;
  logic [AW-1:0]         ram_ri;

  assign in_clk_wr = wr_addr < AW'(CLK_REGS);
  assign in_clk_rd = rd_addr < AW'(CLK_REGS);
  assign ram_wi    = wr_addr - AW'(CLK_REGS);
  assign ram_ri    = rd_addr - AW'(CLK_REGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RAM_N; i++) ram[i] <= '0;
    end else if (wr_en && !in_clk_wr) begin
      ram[ram_wi] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         snap <= '0;
    else if (snap_take) snap <= time_i;
  end

  always_comb begin
    if (in_clk_rd) rd_data = snap[8*rd_addr[CAW-1:0] +: 8];
    else           rd_data = ram[ram_ri];
  end

  assign clk_wr_valid = wr_en && in_clk_wr;
  assign clk_wr_addr  = wr_addr[CAW-1:0];
  assign clk_wr_data  = wr_data;

  // R5: the snapshot moves only at a START
  p_snap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_take |=> $stable(snap));
endmodule

// File: rtl/i2cs_proto.sv
module i2cs_proto
  import i2cs_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         AW       = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inhibit,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          snap_take,
  output logic          sda_oe
);
  i2cs_state_e st;
  logic [3:0]  bitcnt;
  logic [7:0]  shreg;
  logic        in_ack;
  logic        rw;
  logic        nack;

  assign snap_take = start_ev && !inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; shreg <= '0; in_ack <= 1'b0; rw <= 1'b0;
      nack <= 1'b0; ptr <= '0; wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
      sda_oe <= 1'b0;
    end else if (inhibit) begin
      st <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0; ptr <= '0;
      wr_en <= 1'b0; sda_oe <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        st <= ST_ADDR; bitcnt <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (st == ST_RD) begin
        if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            if (nack) begin
              st <= ST_IDLE; sda_oe <= 1'b0;
            end else begin
              shreg <= rd_data; sda_oe <= ~rd_data[7]; bitcnt <= '0;
            end
          end else if (bitcnt == 4'd7) begin
            sda_oe <= 1'b0; in_ack <= 1'b1; ptr <= ptr + 1'b1; bitcnt <= 4'd8;
          end else begin
            shreg <= {shreg[6:0], 1'b0}; sda_oe <= ~shreg[6]; bitcnt <= bitcnt + 1'b1;
          end
        end else if (scl_rise && in_ack) begin
          nack <= sda_s;
        end
      end else if (st != ST_IDLE) begin
        if (scl_rise && !in_ack && bitcnt < 4'd8) begin
          shreg <= {shreg[6:0], sda_s}; bitcnt <= bitcnt + 1'b1;
        end else if (scl_fall && !in_ack && bitcnt == 4'd8) begin
          if (st == ST_ADDR) begin
            if (shreg[7:1] == DEV_ADDR) begin
              rw <= shreg[0]; sda_oe <= 1'b1; in_ack <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end else if (st == ST_PTR) begin
            ptr <= shreg[AW-1:0]; sda_oe <= 1'b1; in_ack <= 1'b1;
          end else begin
            wr_en <= 1'b1; wr_addr <= ptr; wr_data <= shreg; ptr <= ptr + 1'b1;
            sda_oe <= 1'b1; in_ack <= 1'b1;
          end
        end else if (scl_fall && in_ack) begin
          in_ack <= 1'b0; bitcnt <= '0; sda_oe <= 1'b0;
          if (st == ST_ADDR && rw) begin
            st <= ST_RD; shreg <= rd_data; sda_oe <= ~rd_data[7];
          end else if (st == ST_ADDR) begin
            st <= ST_PTR;
          end else begin
            st <= ST_WR;
          end
        end
      end
    end
  end

  // R10: off the bus whenever idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_oe);
  // R8: inhibit clears pointer and releases SDA
  p_inhibit_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (ptr == '0 && !sda_oe));
  // R4: every stored byte leaves the pointer one further, modulo the window
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (ptr == AW'(wr_addr + 1'b1)));
  // R6: SDA is only newly pulled while SCL is low
  p_drive_scl_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         AW          = 6,
  parameter int         CLK_REGS    = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        scl_i,
  input  logic                        sda_i,
  output logic                        sda_oe,
  input  logic                        inhibit,
  input  logic [8*CLK_REGS-1:0]       time_i,
  output logic                        clk_wr_valid,
  output logic [$clog2(CLK_REGS)-1:0] clk_wr_addr,
  output logic [7:0]                  clk_wr_data
);
  logic          scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0]    rd_data;
  logic [AW-1:0] ptr;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          snap_take;

  i2cs_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cs_proto #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_proto (
    .clk(clk), .rst_n(rst_n), .inhibit(inhibit),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .rd_data(rd_data), .ptr(ptr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .snap_take(snap_take), .sda_oe(sda_oe)
  );

  i2cs_regs #(.AW(AW), .CLK_REGS(CLK_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data),
    .snap_take(snap_take), .time_i(time_i),
    .clk_wr_valid(clk_wr_valid), .clk_wr_addr(clk_wr_addr),
    .clk_wr_data(clk_wr_data)
  );
endmodule

// File: tb/i2cs_regfile_tb.sv
module i2cs_regfile_tb;
  localparam int Q = 10;
  localparam logic [7:0] AW_W = 8'hD0;
  localparam logic [7:0] AW_R = 8'hD1;
  localparam int NV = 6;
  // {address, data} pairs in RAM space
  localparam logic [13:0] VEC [NV] = '{
    {6'h08, 8'h81}, {6'h09, 8'h7E}, {6'h15, 8'hA5},
    {6'h2A, 8'h01}, {6'h3E, 8'hFF}, {6'h30, 8'h3C}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        inhibit = 1'b0;
  logic [63:0] time_i = 64'h0;
  logic        sda_oe;
  logic        clk_wr_valid;
  logic [2:0]  clk_wr_addr;
  logic [7:0]  clk_wr_data;
  logic        sda_line;
  int          n_chk = 0;
  int          n_bad = 0;
  int          n_strobe = 0;
  logic [10:0] last_strobe = '0;
  int          cyc = 0;

  assign sda_line = sda_m & ~sda_oe;

  always #5 clk = ~clk;

  i2cs_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .inhibit(inhibit), .time_i(time_i),
    .clk_wr_valid(clk_wr_valid), .clk_wr_addr(clk_wr_addr),
    .clk_wr_data(clk_wr_data)
  );

  always @(posedge clk) begin
    if (clk_wr_valid) begin
      n_strobe <= n_strobe + 1;
      last_strobe <= {clk_wr_addr, clk_wr_data};
    end
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_line; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask

  task automatic rbyte(input logic last, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin rbit(b); d[i] = b; end
    wbit(last);
  endtask

  task automatic wr_burst(input logic [5:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input int n);
    logic ack;
    bstart();
    wbyte(AW_W, ack); chk("R2 addr ack", ack, 1);
    wbyte({2'b00, a}, ack); chk("R2 ptr ack", ack, 1);
    if (n > 0) begin wbyte(d0, ack); chk("R2 data ack", ack, 1); end
    if (n > 1) begin wbyte(d1, ack); chk("R2 data ack", ack, 1); end
    bstop();
  endtask

  task automatic rd_at(input logic [5:0] a, output logic [7:0] d);
    logic ack;
    bstart(); wbyte(AW_W, ack); wbyte({2'b00, a}, ack);
    bstart(); wbyte(AW_R, ack); chk("R3 read addr ack", ack, 1);
    rbyte(1'b1, d); bstop();
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    logic [63:0] t0;
    wq(5);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R10 reset strobe", clk_wr_valid, 0);
    rst_n = 1'b1; wq(5);

    // R10: RAM reads as zero after reset
    rd_at(6'h12, d); chk("R10 ram reset value", d, 8'h00);

    // R1: foreign address is ignored, including the following byte
    bstart(); wbyte(8'hA2, ack); chk("R1 foreign addr nack", ack, 0);
    wbyte(8'h55, ack); chk("R1 later byte nack", ack, 0); bstop();
    bstart(); wbyte(8'hD2, ack); chk("R1 near-miss addr nack", ack, 0); bstop();

    // R2/R3/R6: vector table, single byte write then random read
    for (int v = 0; v < NV; v++) begin
      wr_burst(VEC[v][13:8], VEC[v][7:0], 8'h00, 1);
      rd_at(VEC[v][13:8], d);
      chk("R2 R6 table readback", d, VEC[v][7:0]);
    end
    chk("R9 no strobe for RAM writes", n_strobe, 0);

    // R2/R3: burst write, burst read, then a read that continues from the pointer
    bstart(); wbyte(AW_W, ack); wbyte(8'h20, ack);
    wbyte(8'hAA, ack); wbyte(8'hBB, ack); wbyte(8'hCC, ack); wbyte(8'hDD, ack);
    chk("R2 burst last ack", ack, 1); bstop();
    bstart(); wbyte(AW_W, ack); wbyte(8'h20, ack); bstop();
    bstart(); wbyte(AW_R, ack);
    rbyte(1'b0, d); chk("R3 burst byte0", d, 8'hAA);
    rbyte(1'b0, d); chk("R3 burst byte1", d, 8'hBB);
    rbyte(1'b1, d); chk("R3 burst byte2", d, 8'hCC);
    bstop();
    bstart(); wbyte(AW_R, ack); rbyte(1'b1, d); chk("R3 pointer persists", d, 8'hDD); bstop();

    // R4/R9: write burst wraps from 3Fh into time byte 0
    wr_burst(6'h3F, 8'h5A, 8'h77, 2);
    chk("R9 strobe count", n_strobe, 1);
    chk("R9 strobe addr/data", last_strobe, {3'd0, 8'h77});
    time_i = 64'h1122334455667788;
    bstart(); wbyte(AW_W, ack); wbyte(8'h3F, ack);
    bstart(); wbyte(AW_R, ack);
    rbyte(1'b0, d); chk("R4 read at 3Fh", d, 8'h5A);
    rbyte(1'b1, d); chk("R4 wrap to 00h", d, 8'h88);
    bstop();

    // R5: live time changes during a burst read of the snapshot
    t0 = 64'h0F0E0D0C0B0A0908;
    time_i = t0;
    bstart(); wbyte(AW_W, ack); wbyte(8'h00, ack);
    bstart(); wbyte(AW_R, ack);
    for (int i = 0; i < 8; i++) begin
      rbyte(i == 7, d);
      chk("R5 snapshot byte", d, t0[8*i +: 8]);
      time_i = time_i + 64'h0101010101010101;
    end
    // R7: after the NACK the line is released
    wq(3 * Q);
    chk("R7 released after nack", sda_oe, 0);
    chk("R7 line high after nack", sda_line, 1);
    bstop();

    // R8: inhibit mid-byte, START during inhibit, pointer cleared
    time_i = 64'h00000000000000C3;
    bstart(); wbyte(AW_W, ack); wbyte(8'h30, ack);
    for (int i = 7; i >= 4; i--) wbit(1'b1);
    inhibit = 1'b1; wq(4);
    chk("R8 released under inhibit", sda_oe, 0);
    for (int i = 3; i >= 0; i--) wbit(1'b0);
    bstop();
    bstart(); wbyte(AW_W, ack); chk("R8 START ignored under inhibit", ack, 0); bstop();
    inhibit = 1'b0; wq(Q);
    bstart(); wbyte(AW_R, ack); rbyte(1'b1, d); chk("R8 pointer cleared", d, 8'hC3); bstop();
    rd_at(6'h30, d); chk("R8 aborted byte not stored", d, 8'h3C);
    chk("R9 no strobe since wrap", n_strobe, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule